// File: doc/BRIEF.md
# External Memory Cycle Sequencer

This block generates byte-wide memory cycles on an external bus that another agent normally owns and that has been handed over for the moment. An ownership controller outside the block reports whether the bus is held. While it is held, the sequencer runs four kinds of operation. A single read returns one byte. A single write stores one byte. A fill stores one constant byte over a run of consecutive addresses. A copy stores a run of bytes taken from a local source stream. Every strobe phase lasts a fixed number of clock cycles, set by parameters. The external pads are assumed to be split into an output driver with an enable and an input path.

Commands arrive on a valid/ready interface. `cmd_ready` is high only while the sequencer is idle, so a pending command waits with `cmd_valid` held high until the current operation has finished. Copy bytes arrive on a second valid/ready stream. The sequencer asks for a byte only in the address-setup phase of each copied byte. If the source stalls, that phase is stretched: memory-request stays low and both strobes stay high until a byte is accepted. The end of every operation is marked by a one-cycle `done` pulse. `err` is valid in the same cycle. `rd_data` holds the last byte read.

Top module: `ext_mem_seq`

## Requirements
- R1: While reset is asserted and after it is released, memory-request, read and write strobes are high, the data driver enable is low, `done`, `err` and `src_ready` are low, and `cmd_ready` is high.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is low from that edge until the operation has ended. The operation codes on `cmd_op` are 0 for read, 1 for write, 2 for fill and 3 for copy.
- R3: The 19-bit cycle address appears as `mem_addr_lo` (bits 7:0), `mem_addr_hi` (bits 15:8) and `mem_bank` (bits 18:16). All three change together, and they are stable while any strobe is low.
- R4: A single write asserts memory-request for one setup cycle. It then drives `cmd_wdata` for two cycles with write high, holds write low for two cycles, and raises write for one cycle with the data still driven. Memory-request rises in the following cycle.
- R5: A read asserts memory-request for one setup cycle with the driver off. It then holds read low for three cycles and captures `mem_din` at the end of the third. Read rises for one cycle, then memory-request rises. `rd_data` keeps the captured byte until the next read completes.
- R6: A fill of N bytes writes `cmd_wdata` to N consecutive addresses, and each byte uses the write timing of R4. Memory-request stays low from the first setup to the last write release. The address wraps modulo 2^19.
- R7: A copy of N bytes writes the next accepted `src_data` byte at each address, with the timing of R6. `src_ready` is high only in the setup cycle of a copy byte. A source stall stretches that setup cycle with both strobes high.
- R8: The data driver enable is high only from the first data-drive cycle of a byte to its write-release cycle, and never while read is low.
- R9: A fill or copy with `cmd_len` equal to 0 produces `done` in the cycle after acceptance, with no strobe and memory-request high.
- R10: A command accepted while `bus_owned` is low produces no strobe. `done` and `err` are both high in the cycle after acceptance. `err` is low in every other cycle.
- R11: `done` is high for exactly one cycle. For the operations that complete normally, this is the cycle in which memory-request has just risen. `cmd_ready` returns high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_owned | input | 1 | High while the external bus is held by this side |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_op | input | 2 | Operation: 0 read, 1 write, 2 fill, 3 copy |
| cmd_addr | input | 19 | Start address |
| cmd_wdata | input | 8 | Write or fill byte |
| cmd_len | input | 19 | Byte count for fill and copy |
| src_valid | input | 1 | Copy source byte present |
| src_ready | output | 1 | Copy source byte taken this cycle if valid |
| src_data | input | 8 | Copy source byte |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Command rejected, valid with done |
| rd_data | output | 8 | Last byte read |
| mem_addr_lo | output | 8 | Address bits 7:0 |
| mem_addr_hi | output | 8 | Address bits 15:8 |
| mem_bank | output | 3 | Address bits 18:16 |
| mem_mreq_n | output | 1 | Memory request, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_dout | output | 8 | Data to the bus |
| mem_doe | output | 1 | Data driver enable, active high |
| mem_din | input | 8 | Data from the bus |

## Verification
Single writes and reads are run back to back, and each read answers with a byte derived from its address. This separates a correct capture point from one a cycle early or late, and it shows that `rd_data` survives a later write. Fills are started just below a 16-bit boundary and at the top of the address space. These show whether the low, high and bank fields step together and wrap, and whether memory-request stays low between bytes. Copies are fed with no stall and with stalls of one and two cycles, which tells a stretched setup phase apart from a skipped or repeated byte. Zero-length runs and commands issued without bus ownership show that no strobe is asserted and that `err` is raised only on rejection.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_FILL  = 2'd2,
    OP_COPY  = 2'd3
  } mcs_op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SET,
    PH_DRV,
    PH_WSTB,
    PH_WREL,
    PH_RSTB,
    PH_RREL,
    PH_FIN
  } mcs_phase_e;

endpackage

// File: rtl/mcs_addr_gen.sv
module mcs_addr_gen #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr_q <= '0;
    else if (load)
      addr_q <= load_addr;
    else if (step)
      addr_q <= addr_q + ADDR_W'(1);
  end

  assign addr = addr_q;

endmodule

// File: rtl/mcs_data_path.sv
module mcs_data_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_cmd,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              load_src,
  input  logic [DATA_W-1:0] src_data,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wdata_q <= '0;
    else if (load_cmd)
      wdata_q <= cmd_data;
    else if (load_src)
      wdata_q <= src_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (capture)
      rdata_q <= din;
  end

  assign dout    = wdata_q;
  assign rd_data = rdata_q;

endmodule

// File: rtl/mcs_phase_ctl.sv
module mcs_phase_ctl
  import mcs_pkg::*;
#(
  parameter int LEN_W     = 19,
  parameter int DRIVE_CYC = 2,
  parameter int WSTB_CYC  = 2,
  parameter int RSTB_CYC  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  mcs_op_e          acc_op,
  input  logic [LEN_W-1:0] acc_len,
  input  logic             acc_owned,
  input  logic             src_valid,
  output logic             idle,
  output logic             step,
  output logic             capture,
  output logic             load_src,
  output logic             src_ready,
  output logic             mreq_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic             doe,
  output logic             done,
  output logic             err
);

  localparam int TMR_MAX = (DRIVE_CYC > WSTB_CYC)
                           ? ((DRIVE_CYC > RSTB_CYC) ? DRIVE_CYC : RSTB_CYC)
                           : ((WSTB_CYC > RSTB_CYC) ? WSTB_CYC : RSTB_CYC);
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  mcs_phase_e       ph;
  mcs_op_e          op_q;
  logic [LEN_W-1:0] rem_q;
  logic [TMR_W-1:0] tmr_q;
  logic             err_q;
  logic             acc_burst;
  logic             last_byte;

  assign acc_burst = (acc_op == OP_FILL) || (acc_op == OP_COPY);
  assign last_byte = (rem_q == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      op_q  <= OP_READ;
      rem_q <= '0;
      tmr_q <= '0;
      err_q <= 1'b0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          if (accept) begin
            op_q  <= acc_op;
            err_q <= !acc_owned;
            rem_q <= acc_burst ? acc_len : LEN_W'(1);
            if (!acc_owned || (acc_burst && (acc_len == '0)))
              ph <= PH_FIN;
            else
              ph <= PH_SET;
          end
        end
        PH_SET: begin
          if (op_q == OP_READ) begin
            ph    <= PH_RSTB;
            tmr_q <= TMR_W'(RSTB_CYC - 1);
          end else if ((op_q != OP_COPY) || src_valid) begin
            ph    <= PH_DRV;
            tmr_q <= TMR_W'(DRIVE_CYC - 1);
          end
        end
        PH_DRV: begin
          if (tmr_q == '0) begin
            ph    <= PH_WSTB;
            tmr_q <= TMR_W'(WSTB_CYC - 1);
          end else begin
            tmr_q <= tmr_q - TMR_W'(1);
          end
        end
        PH_WSTB: begin
          if (tmr_q == '0)
            ph <= PH_WREL;
          else
            tmr_q <= tmr_q - TMR_W'(1);
        end
        PH_WREL: begin
          if (last_byte) begin
            ph <= PH_FIN;
          end else begin
            rem_q <= rem_q - LEN_W'(1);
            ph    <= PH_SET;
          end
        end
        PH_RSTB: begin
          if (tmr_q == '0)
            ph <= PH_RREL;
          else
            tmr_q <= tmr_q - TMR_W'(1);
        end
        PH_RREL: ph <= PH_FIN;
        PH_FIN:  ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign idle      = (ph == PH_IDLE);
  assign step      = (ph == PH_WREL) && !last_byte;
  assign capture   = (ph == PH_RSTB) && (tmr_q == '0);
  assign src_ready = (ph == PH_SET) && (op_q == OP_COPY);
  assign load_src  = src_ready && src_valid;
  assign mreq_n    = (ph == PH_IDLE) || (ph == PH_FIN);
  assign rd_n      = (ph != PH_RSTB);
  assign wr_n      = (ph != PH_WSTB);
  assign doe       = (ph == PH_DRV) || (ph == PH_WSTB) || (ph == PH_WREL);
  assign done      = (ph == PH_FIN);
  assign err       = (ph == PH_FIN) && err_q;

  // R8: the driver is never on while the read strobe is low
  a_r8_no_drive_during_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !doe);

  // R4: the write strobe only ever sits inside an active memory request
  a_r4_wr_inside_mreq: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !mreq_n);

  // R5: the read strobe only ever sits inside an active memory request
  a_r5_rd_inside_mreq: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !mreq_n);

  // R11: done never lasts two cycles
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: the source is asked for a byte only in a quiet setup cycle
  a_r7_src_only_in_setup: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (!mreq_n && rd_n && wr_n && !doe));

  // R4: the write strobe is always released with the data still driven
  a_r4_release_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> doe);

endmodule

// File: rtl/ext_mem_seq.sv
module ext_mem_seq
  import mcs_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int LEN_W     = 19,
  parameter int DRIVE_CYC = 2,
  parameter int WSTB_CYC  = 2,
  parameter int RSTB_CYC  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_owned,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [1:0]           cmd_op,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [DATA_W-1:0]    cmd_wdata,
  input  logic [LEN_W-1:0]     cmd_len,
  input  logic                 src_valid,
  output logic                 src_ready,
  input  logic [DATA_W-1:0]    src_data,
  output logic                 done,
  output logic                 err,
  output logic [DATA_W-1:0]    rd_data,
  output logic [7:0]           mem_addr_lo,
  output logic [7:0]           mem_addr_hi,
  output logic [ADDR_W-17:0]   mem_bank,
  output logic                 mem_mreq_n,
  output logic                 mem_rd_n,
  output logic                 mem_wr_n,
  output logic [DATA_W-1:0]    mem_dout,
  output logic                 mem_doe,
  input  logic [DATA_W-1:0]    mem_din
);

  localparam int BANK_W = ADDR_W - 16;

  logic              idle;
  logic              accept;
  logic              step;
  logic              capture;
  logic              load_src;
  logic [ADDR_W-1:0] addr;

  assign cmd_ready = idle;
  assign accept    = cmd_valid && idle;

  mcs_phase_ctl #(
    .LEN_W     (LEN_W),
    .DRIVE_CYC (DRIVE_CYC),
    .WSTB_CYC  (WSTB_CYC),
    .RSTB_CYC  (RSTB_CYC)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .acc_op    (mcs_op_e'(cmd_op)),
    .acc_len   (cmd_len),
    .acc_owned (bus_owned),
    .src_valid (src_valid),
    .idle      (idle),
    .step      (step),
    .capture   (capture),
    .load_src  (load_src),
    .src_ready (src_ready),
    .mreq_n    (mem_mreq_n),
    .rd_n      (mem_rd_n),
    .wr_n      (mem_wr_n),
    .doe       (mem_doe),
    .done      (done),
    .err       (err)
  );

  mcs_addr_gen #(
    .ADDR_W (ADDR_W)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_addr (cmd_addr),
    .step      (step),
    .addr      (addr)
  );

  mcs_data_path #(
    .DATA_W (DATA_W)
  ) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_cmd (accept),
    .cmd_data (cmd_wdata),
    .load_src (load_src),
    .src_data (src_data),
    .capture  (capture),
    .din      (mem_din),
    .dout     (mem_dout),
    .rd_data  (rd_data)
  );

  assign mem_addr_lo = addr[7:0];
  assign mem_addr_hi = addr[15:8];
  assign mem_bank    = addr[ADDR_W-1:ADDR_W-BANK_W];

  // R3: the address fields hold still while a strobe stays low
  a_r3_addr_stable_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || !mem_wr_n) |=>
      ((mem_rd_n && mem_wr_n) || $stable({mem_bank, mem_addr_hi, mem_addr_lo})));

  // R10: a command taken without ownership ends at once, flagged, with no request
  a_r10_reject_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !bus_owned) |=> (done && err && mem_mreq_n));

  // R9: an empty fill or copy ends at once without a request
  a_r9_zero_len_quick: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bus_owned && cmd_op[1] && (cmd_len == '0)) |=> (done && !err && mem_mreq_n));

  // R2: no command is taken while an operation runs
  a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (mem_mreq_n && !done));

endmodule

// File: tb/test_ext_mem_seq.sv
`timescale 1ns/1ps
module test_ext_mem_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_owned;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_op;
  logic [18:0] cmd_addr;
  logic [7:0]  cmd_wdata;
  logic [18:0] cmd_len;
  logic        src_valid;
  logic        src_ready;
  logic [7:0]  src_data;
  logic        done;
  logic        err;
  logic [7:0]  rd_data;
  logic [7:0]  mem_addr_lo;
  logic [7:0]  mem_addr_hi;
  logic [2:0]  mem_bank;
  logic        mem_mreq_n;
  logic        mem_rd_n;
  logic        mem_wr_n;
  logic [7:0]  mem_dout;
  logic        mem_doe;
  logic [7:0]  mem_din;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  int       stall_q[$];
  bit [7:0] srcb_q[$];
  logic [7:0] last_rd;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [18:0] a);
    return (a[7:0] ^ 8'hC3) + a[15:8] + {5'b0, a[18:16]};
  endfunction

  assign mem_din = mem_fn({mem_bank, mem_addr_hi, mem_addr_lo});

  ext_mem_seq i_ext_mem_seq (
    .clk(clk), .rst_n(rst_n), .bus_owned(bus_owned),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .done(done), .err(err), .rd_data(rd_data),
    .mem_addr_lo(mem_addr_lo), .mem_addr_hi(mem_addr_hi), .mem_bank(mem_bank),
    .mem_mreq_n(mem_mreq_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din)
  );

  // Compare one cycle of the reference model, then move to the next negedge.
  task automatic expect_cyc(input bit m, input bit r, input bit w, input bit oe,
                            input bit sr, input bit dn, input bit er, input bit rdy,
                            input logic [18:0] a, input logic [7:0] d, input string tag);
    logic [18:0] act_a;
    bit ok;
    act_a = {mem_bank, mem_addr_hi, mem_addr_lo};
    ok = (mem_mreq_n === m) && (mem_rd_n === r) && (mem_wr_n === w) &&
         (mem_doe === oe) && (src_ready === sr) && (done === dn) &&
         (err === er) && (cmd_ready === rdy);
    if (!m && (act_a !== a)) ok = 1'b0;
    if (oe && (mem_dout !== d)) ok = 1'b0;
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0t actual mreq=%b rd=%b wr=%b oe=%b srdy=%b done=%b err=%b rdy=%b a=%h d=%h expected %b %b %b %b %b %b %b %b a=%h d=%h",
               tag, $time, mem_mreq_n, mem_rd_n, mem_wr_n, mem_doe, src_ready, done,
               err, cmd_ready, act_a, mem_dout, m, r, w, oe, sr, dn, er, rdy, a, d);
    end
    @(negedge clk);
  endtask

  task automatic check_rd(input logic [7:0] exp, input string tag);
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, exp);
    end
  endtask

  task automatic run_cmd(input int op, input logic [18:0] addr, input logic [7:0] data,
                         input int len, input bit owned, input string tag);
    logic [18:0] a;
    logic [7:0]  d;
    int n;
    bus_owned = owned;
    cmd_op    = 2'(op);
    cmd_addr  = addr;
    cmd_wdata = data;
    cmd_len   = 19'(len);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    a = addr;
    if (!owned) begin
      expect_cyc(1, 1, 1, 0, 0, 1, 1, 0, a, 8'h00, "R10 reject");
    end else if (op >= 2 && len == 0) begin
      expect_cyc(1, 1, 1, 0, 0, 1, 0, 0, a, 8'h00, "R9 empty run");
    end else if (op == 0) begin
      expect_cyc(0, 1, 1, 0, 0, 0, 0, 0, a, 8'h00, "R5 setup");
      repeat (3) expect_cyc(0, 0, 1, 0, 0, 0, 0, 0, a, 8'h00, "R5 strobe");
      expect_cyc(0, 1, 1, 0, 0, 0, 0, 0, a, 8'h00, "R5 release");
      last_rd = mem_fn(a);
      check_rd(last_rd, "R5 capture");
      expect_cyc(1, 1, 1, 0, 0, 1, 0, 0, a, 8'h00, "R11 end of read");
    end else begin
      n = (op == 1) ? 1 : len;
      for (int k = 0; k < n; k++) begin
        d = (op == 3) ? srcb_q[k] : data;
        if (op == 3) begin
          for (int s = 0; s < stall_q[k]; s++) begin
            src_valid = 1'b0;
            expect_cyc(0, 1, 1, 0, 1, 0, 0, 0, a, d, "R7 stalled setup");
          end
          src_valid = 1'b1;
          src_data  = d;
          expect_cyc(0, 1, 1, 0, 1, 0, 0, 0, a, d, "R7 setup take");
          src_valid = 1'b0;
          src_data  = 8'h00;
        end else begin
          expect_cyc(0, 1, 1, 0, 0, 0, 0, 0, a, d, {tag, " R4 setup"});
        end
        repeat (2) expect_cyc(0, 1, 1, 1, 0, 0, 0, 0, a, d, {tag, " R8 drive"});
        repeat (2) expect_cyc(0, 1, 0, 1, 0, 0, 0, 0, a, d, {tag, " R4 strobe"});
        expect_cyc(0, 1, 1, 1, 0, 0, 0, 0, a, d, {tag, " R6 release"});
        a = a + 19'd1;
      end
      expect_cyc(1, 1, 1, 0, 0, 1, 0, 0, a, 8'h00, {tag, " R11 end"});
    end
    expect_cyc(1, 1, 1, 0, 0, 0, 0, 1, a, 8'h00, "R11 back to idle");
    bus_owned = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_owned = 1'b1; cmd_valid = 1'b0; cmd_op = '0;
    cmd_addr = '0; cmd_wdata = '0; cmd_len = '0; src_valid = 1'b0; src_data = '0;
    last_rd = 8'h00;
    repeat (3) @(negedge clk);
    expect_cyc(1, 1, 1, 0, 0, 0, 0, 1, 19'h0, 8'h00, "R1 in reset");
    rst_n = 1'b1;
    expect_cyc(1, 1, 1, 0, 0, 0, 0, 1, 19'h0, 8'h00, "R1 after reset");
    check_rd(8'h00, "R1 rd_data");

    // single write and reads (R2 op codes, R3 split, R4, R5)
    run_cmd(1, 19'h5A3C7, 8'hA5, 0, 1'b1, "R4 write");
    run_cmd(0, 19'h5A3C7, 8'h00, 0, 1'b1, "R5 read");
    run_cmd(0, 19'h7FFFF, 8'h00, 0, 1'b1, "R5 read top");
    run_cmd(1, 19'h00010, 8'h3C, 0, 1'b1, "R2 write");
    check_rd(last_rd, "R5 rd_data held after write");

    // fills across a 16-bit boundary and across the top (R3, R6)
    run_cmd(2, 19'h2FFFE, 8'h96, 3, 1'b1, "R6 fill boundary");
    run_cmd(2, 19'h7FFFF, 8'h4B, 2, 1'b1, "R6 fill wrap");

    // copy with stalls (R7)
    stall_q = '{0, 2, 1};
    srcb_q  = '{8'h11, 8'hE2, 8'h7D};
    run_cmd(3, 19'h10203, 8'h00, 3, 1'b1, "R7 copy");

    // empty runs (R9)
    run_cmd(2, 19'h00100, 8'hFF, 0, 1'b1, "R9 fill");
    run_cmd(3, 19'h00200, 8'hFF, 0, 1'b1, "R9 copy");

    // rejection without ownership (R10)
    run_cmd(1, 19'h00300, 8'h77, 0, 1'b0, "R10 write");
    run_cmd(0, 19'h00301, 8'h00, 0, 1'b0, "R10 read");
    check_rd(last_rd, "R10 rd_data untouched");
    run_cmd(0, 19'h01234, 8'h00, 0, 1'b1, "R5 read after reject");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule